// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch state of every hardware thread in an instruction-fetch stage. Each cycle it absorbs block and unblock pulses from four downstream stages, redirect requests from the retire stage and from the decode stage, a reorder-buffer-still-squashing flag, a context-switch flag, instruction-cache request issue and retry events, and cache response events tagged with a request identifier. From these it produces each thread's state, its redirected PC and next PC, a per-thread squashing indication, a cache-blocked flag, a stale-response pulse and one aggregate flag that tells the rest of the pipeline whether the fetch stage has useful work.

Each thread moves among six states: RUN (0), SQUASH (1), BLOCK (2), WAIT_RESP (3, a cache line is outstanding), WAIT_RETRY (4, the cache refused the request) and ACC_DONE (5, the line has arrived). The transitions, in falling priority, are: retire redirect to SQUASH from any state; reorder-buffer squashing keeps or puts the thread in SQUASH; decode redirect to SQUASH from any state but SQUASH; a stall or context switch to BLOCK from any state but WAIT_RESP; BLOCK or SQUASH back to RUN; then, by state, RUN to WAIT_RESP or WAIT_RETRY on an issued request, WAIT_RETRY to WAIT_RESP on a retry grant, WAIT_RESP to ACC_DONE (or to BLOCK when stalled) on a matching response, and ACC_DONE to RUN.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is in RUN (state code 0), its PC equals RESET_PC and its next PC equals RESET_PC + INST_BYTES, all stall flags and the cache-blocked flag are clear.
- R2: Each stage has a sticky stall flag per thread, bit `stall_set[s*NTHR+t]` sets it and `stall_clr[s*NTHR+t]` clears it; while any flag of a thread is set and its state is not WAIT_RESP, the thread is in BLOCK (code 2) from the next cycle, and it returns to RUN the cycle after the last flag clears.
- R3: A retire redirect for a thread has top priority: on the next cycle the thread is in SQUASH (code 1), its PC equals the target and its next PC equals the target plus INST_BYTES, and its outstanding cache request is abandoned.
- R4: Without a retire redirect, a set reorder-buffer-squashing flag keeps or puts the thread in SQUASH and leaves its PC unchanged.
- R5: A decode redirect loads the PC and enters SQUASH only when the thread is not already in SQUASH; otherwise it has no effect on PC or state.
- R6: An asserted context-switch flag moves every thread that is not in WAIT_RESP and has no redirect or squash pending to BLOCK.
- R7: A thread in BLOCK or SQUASH with no redirect, squash flag, stall or context switch returns to RUN on the next cycle.
- R8: A request issued for a thread in RUN while the cache is not blocked moves it to WAIT_RESP (code 3) when accepted, or to WAIT_RETRY (code 4) with cache-blocked set when refused; a request issued while cache-blocked is set has no effect.
- R9: A cache response is discarded, with `resp_dropped` high in the same cycle and the thread state unchanged, when its thread is not in WAIT_RESP or its tag differs from the tag of the thread's last issued request.
- R10: An accepted response moves the thread to ACC_DONE (code 5), or to BLOCK when a stall flag or context switch is active; ACC_DONE returns to RUN on the next cycle.
- R11: A retry grant clears cache-blocked and moves the owning thread from WAIT_RETRY to WAIT_RESP; a redirect of the owning thread also clears cache-blocked.
- R12: `stage_active` is high exactly when some thread enabled in `thr_active` is in RUN, SQUASH or ACC_DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | NTHR | Threads that count toward stage activity |
| ctx_switch | input | 1 | Context switch in progress |
| stall_set | input | NSTAGE*NTHR | Block pulses, index stage*NTHR+thread |
| stall_clr | input | NSTAGE*NTHR | Unblock pulses, same indexing |
| cmt_squash | input | NTHR | Retire redirect per thread |
| cmt_target | input | NTHR*PCW | Retire redirect targets |
| rob_squashing | input | NTHR | Reorder buffer still squashing |
| dec_squash | input | NTHR | Decode redirect per thread |
| dec_target | input | NTHR*PCW | Decode redirect targets |
| req_valid | input | 1 | Cache request issued |
| req_tid | input | TID_W | Thread of the issued request |
| req_tag | input | TAGW | Tag of the issued request |
| req_accepted | input | 1 | Cache accepted the request |
| retry_grant | input | 1 | Cache can now take the refused request |
| rsp_valid | input | 1 | Cache response event |
| rsp_tid | input | TID_W | Thread of the response |
| rsp_tag | input | TAGW | Tag of the response |
| thr_state | output | 3*NTHR | State code per thread |
| thr_pc | output | NTHR*PCW | PC per thread |
| thr_npc | output | NTHR*PCW | Next PC per thread |
| thr_squashing | output | NTHR | Thread is in SQUASH |
| cache_blocked | output | 1 | A refused request awaits retry |
| resp_dropped | output | 1 | Current response is stale |
| stage_active | output | 1 | Fetch stage has work |

## Verification
The bench builds the block with two threads, four stages, a 16-bit PC and a 2-bit tag. The tiny tag space makes random responses hit the outstanding tag about half the time, so both accepted and stale responses occur often, and two threads let one thread own a pending retry while the other is redirected or tries to issue into a blocked cache.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    typedef enum logic [2:0] {
        FS_RUN        = 3'd0,
        FS_SQUASH     = 3'd1,
        FS_BLOCK      = 3'd2,
        FS_WAIT_RESP  = 3'd3,
        FS_WAIT_RETRY = 3'd4,
        FS_ACC_DONE   = 3'd5
    } fstate_e;
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
    parameter int NSTAGE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSTAGE-1:0] set_i,
    input  logic [NSTAGE-1:0] clr_i,
    output logic              stalled_o
);
    logic [NSTAGE-1:0] flags_q;
    logic [NSTAGE-1:0] flags_n;

    // clear after set: an unblock is never paired with a block
    assign flags_n   = (flags_q | set_i) & ~clr_i;
    assign stalled_o = |flags_n;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_n;
    end
endmodule

// File: rtl/fsc_retry_tracker.sv
module fsc_retry_tracker #(
    parameter int NTHR  = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_any,
    input  logic             req_accepted,
    input  logic [TID_W-1:0] req_tid,
    input  logic             retry_grant,
    input  logic [NTHR-1:0]  squash_fire,
    output logic             blocked_o,
    output logic [TID_W-1:0] owner_o
);
    logic             blk_q, blk_n;
    logic [TID_W-1:0] own_q, own_n;

    always_comb begin
        blk_n = blk_q;
        own_n = own_q;
        if (blk_q) begin
            if (retry_grant || squash_fire[own_q]) blk_n = 1'b0;
        end else if (issue_any && !req_accepted) begin
            blk_n = 1'b1;
            own_n = req_tid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= 1'b0;
            own_q <= '0;
        end else begin
            blk_q <= blk_n;
            own_q <= own_n;
        end
    end

    assign blocked_o = blk_q;
    assign owner_o   = own_q;
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int              PCW        = 32,
    parameter int              TAGW       = 4,
    parameter int              TID_W      = 2,
    parameter int              INST_BYTES = 4,
    parameter logic [PCW-1:0]  RESET_PC   = '0,
    parameter int              MY_TID     = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stalled,
    input  logic             cmt_sq,
    input  logic [PCW-1:0]   cmt_tgt,
    input  logic             rob_sq,
    input  logic             dec_sq,
    input  logic [PCW-1:0]   dec_tgt,
    input  logic             req_valid,
    input  logic [TID_W-1:0] req_tid,
    input  logic [TAGW-1:0]  req_tag,
    input  logic             req_accepted,
    input  logic             cache_blocked,
    input  logic             retry_mine,
    input  logic             retry_grant,
    input  logic             rsp_valid,
    input  logic [TID_W-1:0] rsp_tid,
    input  logic [TAGW-1:0]  rsp_tag,
    output fstate_e          state_o,
    output logic [PCW-1:0]   pc_o,
    output logic [PCW-1:0]   npc_o,
    output logic             squash_fire,
    output logic             issue_take,
    output logic             rsp_drop
);
    localparam logic [TID_W-1:0] ME   = TID_W'(MY_TID);
    localparam logic [PCW-1:0]   STEP = PCW'(INST_BYTES);

    fstate_e         st_q, st_n;
    logic [PCW-1:0]  pc_q, pc_n, npc_q, npc_n;
    logic [TAGW-1:0] tag_q, tag_n;
    logic            rsp_mine, rsp_hit;

    assign rsp_mine = rsp_valid && (rsp_tid == ME);
    assign rsp_hit  = rsp_mine && (st_q == FS_WAIT_RESP) && (rsp_tag == tag_q);

    // next-state process
    always_comb begin
        st_n        = st_q;
        pc_n        = pc_q;
        npc_n       = npc_q;
        tag_n       = tag_q;
        squash_fire = 1'b0;
        issue_take  = 1'b0;
        if (cmt_sq) begin
            pc_n        = cmt_tgt;
            npc_n       = cmt_tgt + STEP;
            st_n        = FS_SQUASH;
            squash_fire = 1'b1;
        end else if (rob_sq) begin
            st_n = FS_SQUASH;
        end else if (dec_sq && st_q != FS_SQUASH) begin
            pc_n        = dec_tgt;
            npc_n       = dec_tgt + STEP;
            st_n        = FS_SQUASH;
            squash_fire = 1'b1;
        end else if (stalled && st_q != FS_WAIT_RESP) begin
            st_n = FS_BLOCK;
        end else begin
            unique case (st_q)
                FS_BLOCK, FS_SQUASH: st_n = FS_RUN;
                FS_WAIT_RESP: begin
                    if (rsp_hit) st_n = stalled ? FS_BLOCK : FS_ACC_DONE;
                end
                FS_WAIT_RETRY: begin
                    if (retry_grant && retry_mine) st_n = FS_WAIT_RESP;
                end
                FS_RUN: begin
                    if (req_valid && req_tid == ME && !cache_blocked) begin
                        issue_take = 1'b1;
                        tag_n      = req_tag;
                        st_n       = req_accepted ? FS_WAIT_RESP : FS_WAIT_RETRY;
                    end
                end
                FS_ACC_DONE: st_n = FS_RUN;
                default:     st_n = FS_RUN;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FS_RUN;
            pc_q  <= RESET_PC;
            npc_q <= RESET_PC + STEP;
            tag_q <= '0;
        end else begin
            st_q  <= st_n;
            pc_q  <= pc_n;
            npc_q <= npc_n;
            tag_q <= tag_n;
        end
    end

    // output process
    always_comb begin
        state_o  = st_q;
        pc_o     = pc_q;
        npc_o    = npc_q;
        rsp_drop = rsp_mine && !rsp_hit;
    end
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int             NTHR       = 4,
    parameter int             NSTAGE     = 4,
    parameter int             PCW        = 32,
    parameter int             TAGW       = 4,
    parameter int             INST_BYTES = 4,
    parameter logic [PCW-1:0] RESET_PC   = '0,
    localparam int            TID_W      = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NTHR-1:0]        thr_active,
    input  logic                   ctx_switch,
    input  logic [NSTAGE*NTHR-1:0] stall_set,
    input  logic [NSTAGE*NTHR-1:0] stall_clr,
    input  logic [NTHR-1:0]        cmt_squash,
    input  logic [NTHR*PCW-1:0]    cmt_target,
    input  logic [NTHR-1:0]        rob_squashing,
    input  logic [NTHR-1:0]        dec_squash,
    input  logic [NTHR*PCW-1:0]    dec_target,
    input  logic                   req_valid,
    input  logic [TID_W-1:0]       req_tid,
    input  logic [TAGW-1:0]        req_tag,
    input  logic                   req_accepted,
    input  logic                   retry_grant,
    input  logic                   rsp_valid,
    input  logic [TID_W-1:0]       rsp_tid,
    input  logic [TAGW-1:0]        rsp_tag,
    output logic [3*NTHR-1:0]      thr_state,
    output logic [NTHR*PCW-1:0]    thr_pc,
    output logic [NTHR*PCW-1:0]    thr_npc,
    output logic [NTHR-1:0]        thr_squashing,
    output logic                   cache_blocked,
    output logic                   resp_dropped,
    output logic                   stage_active
);
    logic [NTHR-1:0]  squash_fire, issue_take, rsp_drop, live, stalled;
    logic [TID_W-1:0] retry_owner;
    fstate_e          st [NTHR];

    genvar t;
    generate
        for (t = 0; t < NTHR; t++) begin : g_thr
            logic [NSTAGE-1:0] set_v, clr_v;
            for (genvar s = 0; s < NSTAGE; s++) begin : g_stg
                assign set_v[s] = stall_set[s*NTHR + t];
                assign clr_v[s] = stall_clr[s*NTHR + t];
            end

            logic stall_any;
            fsc_stall_flags #(.NSTAGE(NSTAGE)) u_flags (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (set_v),
                .clr_i    (clr_v),
                .stalled_o(stall_any)
            );
            assign stalled[t] = stall_any | ctx_switch;

            fsc_thread_fsm #(
                .PCW(PCW), .TAGW(TAGW), .TID_W(TID_W),
                .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC), .MY_TID(t)
            ) u_fsm (
                .clk          (clk),
                .rst_n        (rst_n),
                .stalled      (stalled[t]),
                .cmt_sq       (cmt_squash[t]),
                .cmt_tgt      (cmt_target[t*PCW +: PCW]),
                .rob_sq       (rob_squashing[t]),
                .dec_sq       (dec_squash[t]),
                .dec_tgt      (dec_target[t*PCW +: PCW]),
                .req_valid    (req_valid),
                .req_tid      (req_tid),
                .req_tag      (req_tag),
                .req_accepted (req_accepted),
                .cache_blocked(cache_blocked),
                .retry_mine   (cache_blocked && retry_owner == TID_W'(t)),
                .retry_grant  (retry_grant),
                .rsp_valid    (rsp_valid),
                .rsp_tid      (rsp_tid),
                .rsp_tag      (rsp_tag),
                .state_o      (st[t]),
                .pc_o         (thr_pc[t*PCW +: PCW]),
                .npc_o        (thr_npc[t*PCW +: PCW]),
                .squash_fire  (squash_fire[t]),
                .issue_take   (issue_take[t]),
                .rsp_drop     (rsp_drop[t])
            );

            assign thr_state[3*t +: 3] = st[t];
            assign thr_squashing[t]    = (st[t] == FS_SQUASH);
            assign live[t] = thr_active[t] &&
                             (st[t] == FS_RUN || st[t] == FS_SQUASH || st[t] == FS_ACC_DONE);
        end
    endgenerate

    fsc_retry_tracker #(.NTHR(NTHR), .TID_W(TID_W)) u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_any   (|issue_take),
        .req_accepted(req_accepted),
        .req_tid     (req_tid),
        .retry_grant (retry_grant),
        .squash_fire (squash_fire),
        .blocked_o   (cache_blocked),
        .owner_o     (retry_owner)
    );

    assign resp_dropped = |rsp_drop;
    assign stage_active = |live;
endmodule

// File: rtl/fetch_status_ctrl_chk.sv
module fetch_status_ctrl_chk
    import fsc_pkg::*;
#(
    parameter int  NTHR       = 4,
    parameter int  PCW        = 32,
    parameter int  INST_BYTES = 4,
    parameter int  TID_W      = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NTHR-1:0]     cmt_squash,
    input logic [NTHR*PCW-1:0] cmt_target,
    input logic [NTHR-1:0]     rob_squashing,
    input logic [NTHR-1:0]     dec_squash,
    input logic                rsp_valid,
    input logic [TID_W-1:0]    rsp_tid,
    input logic                retry_grant,
    input logic [3*NTHR-1:0]   thr_state,
    input logic [NTHR*PCW-1:0] thr_pc,
    input logic [NTHR*PCW-1:0] thr_npc,
    input logic                cache_blocked,
    input logic                resp_dropped
);
    genvar t;
    generate
        for (t = 0; t < NTHR; t++) begin : g_a
            AST_CMT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
                cmt_squash[t] |=> (thr_state[3*t +: 3] == 3'(FS_SQUASH)) &&
                                  (thr_pc[t*PCW +: PCW] == $past(cmt_target[t*PCW +: PCW]))); // R3
            AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                cmt_squash[t] |=> thr_npc[t*PCW +: PCW] == thr_pc[t*PCW +: PCW] + PCW'(INST_BYTES)); // R3
            AST_ROB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!cmt_squash[t] && rob_squashing[t]) |=>
                    (thr_state[3*t +: 3] == 3'(FS_SQUASH)) && $stable(thr_pc[t*PCW +: PCW])); // R4
            AST_DEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
                (thr_state[3*t +: 3] == 3'(FS_SQUASH) && dec_squash[t] && !cmt_squash[t])
                    |=> $stable(thr_pc[t*PCW +: PCW])); // R5
        end
    endgenerate

    AST_DROP_WRONG_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && thr_state[3*rsp_tid +: 3] != 3'(FS_WAIT_RESP)) |-> resp_dropped); // R9
    AST_GRANT_UNBLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_blocked && retry_grant) |=> !cache_blocked); // R11
endmodule

bind fetch_status_ctrl fetch_status_ctrl_chk #(
    .NTHR(NTHR), .PCW(PCW), .INST_BYTES(INST_BYTES), .TID_W(TID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmt_squash(cmt_squash), .cmt_target(cmt_target),
    .rob_squashing(rob_squashing), .dec_squash(dec_squash), .rsp_valid(rsp_valid),
    .rsp_tid(rsp_tid), .retry_grant(retry_grant), .thr_state(thr_state),
    .thr_pc(thr_pc), .thr_npc(thr_npc), .cache_blocked(cache_blocked),
    .resp_dropped(resp_dropped)
);

// File: tb/fetch_status_ctrl_bench.sv
module fetch_status_ctrl_bench;
    localparam int NT = 2, NS = 4, PW = 16, TW = 2, IB = 4, TIDW = 1;
    localparam logic [PW-1:0] RPC = 16'h0040;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NT-1:0]    thr_active;
    logic             ctx_switch;
    logic [NS*NT-1:0] stall_set, stall_clr;
    logic [NT-1:0]    cmt_squash, rob_squashing, dec_squash;
    logic [NT*PW-1:0] cmt_target, dec_target;
    logic             req_valid, req_accepted, retry_grant, rsp_valid;
    logic [TIDW-1:0]  req_tid, rsp_tid;
    logic [TW-1:0]    req_tag, rsp_tag;
    logic [3*NT-1:0]  thr_state;
    logic [NT*PW-1:0] thr_pc, thr_npc;
    logic [NT-1:0]    thr_squashing;
    logic             cache_blocked, resp_dropped, stage_active;

    fetch_status_ctrl #(.NTHR(NT), .NSTAGE(NS), .PCW(PW), .TAGW(TW),
                        .INST_BYTES(IB), .RESET_PC(RPC)) u_fetch_status_ctrl (.*);

    int checks = 0, errors = 0;

    // reference model, codes: RUN 0, SQUASH 1, BLOCK 2, WAIT_RESP 3, WAIT_RETRY 4, ACC_DONE 5
    int            m_st [NT];
    logic [PW-1:0] m_pc [NT], m_npc [NT];
    logic [NS-1:0] m_stall [NT];
    logic [TW-1:0] m_tag [NT];
    bit            m_blk;
    int            m_owner;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_pc[t] = RPC; m_npc[t] = RPC + PW'(IB);
            m_stall[t] = '0; m_tag[t] = '0;
        end
        m_blk = 0; m_owner = 0;
    endtask

    function automatic bit exp_drop();
        if (!rsp_valid) return 0;
        return !(m_st[rsp_tid] == 3 && rsp_tag == m_tag[rsp_tid]);
    endfunction

    function automatic bit exp_active();
        for (int t = 0; t < NT; t++)
            if (thr_active[t] && (m_st[t] == 0 || m_st[t] == 1 || m_st[t] == 5)) return 1;
        return 0;
    endfunction

    task automatic model_step();
        bit sqf [NT];
        bit issue_any = 0;
        for (int t = 0; t < NT; t++) begin
            logic [NS-1:0] ns;
            bit stl;
            int st = m_st[t];
            int nst = st;
            for (int s = 0; s < NS; s++)
                ns[s] = (m_stall[t][s] | stall_set[s*NT+t]) & ~stall_clr[s*NT+t];
            stl = (|ns) | ctx_switch;
            sqf[t] = 0;
            if (cmt_squash[t]) begin
                m_pc[t] = cmt_target[t*PW +: PW]; m_npc[t] = m_pc[t] + PW'(IB); nst = 1; sqf[t] = 1;
            end else if (rob_squashing[t]) nst = 1;
            else if (dec_squash[t] && st != 1) begin
                m_pc[t] = dec_target[t*PW +: PW]; m_npc[t] = m_pc[t] + PW'(IB); nst = 1; sqf[t] = 1;
            end else if (stl && st != 3) nst = 2;
            else if (st == 1 || st == 2) nst = 0;
            else if (st == 3) begin
                if (rsp_valid && int'(rsp_tid) == t && rsp_tag == m_tag[t]) nst = stl ? 2 : 5;
            end else if (st == 4) begin
                if (retry_grant && m_blk && m_owner == t) nst = 3;
            end else if (st == 0) begin
                if (req_valid && int'(req_tid) == t && !m_blk) begin
                    issue_any = 1; m_tag[t] = req_tag; nst = req_accepted ? 3 : 4;
                end
            end else if (st == 5) nst = 0;
            m_st[t] = nst;
            m_stall[t] = ns;
        end
        if (m_blk) begin
            if (retry_grant || sqf[m_owner]) m_blk = 0;
        end else if (issue_any && !req_accepted) begin
            m_blk = 1; m_owner = int'(req_tid);
        end
    endtask

    task automatic compare_all();
        for (int t = 0; t < NT; t++) begin
            chk("R2 R4 R6 R7 R8 R10 state", int'(thr_state[3*t +: 3]), m_st[t]);
            chk("R3 R5 pc", int'(thr_pc[t*PW +: PW]), int'(m_pc[t]));
            chk("R3 npc", int'(thr_npc[t*PW +: PW]), int'(m_npc[t]));
        end
        chk("R11 cache_blocked", int'(cache_blocked), int'(m_blk));
        chk("R12 stage_active", int'(stage_active), int'(exp_active()));
    endtask

    // inputs are set at a falling edge; one call spans one rising edge
    task automatic step();
        #1;
        chk("R9 resp_dropped", int'(resp_dropped), int'(exp_drop()));
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        ctx_switch = 0; stall_set = '0; stall_clr = '0;
        cmt_squash = '0; rob_squashing = '0; dec_squash = '0;
        req_valid = 0; req_accepted = 0; retry_grant = 0; rsp_valid = 0;
        req_tid = '0; rsp_tid = '0; req_tag = '0; rsp_tag = '0;
    endtask

    task automatic rand_inputs();
        quiet();
        for (int t = 0; t < NT; t++) begin
            for (int s = 0; s < NS; s++) begin
                int r = $urandom % 24;
                if (r == 0) stall_set[s*NT+t] = 1'b1;
                else if (r < 5 && m_stall[t][s]) stall_clr[s*NT+t] = 1'b1;
            end
            cmt_squash[t]    = ($urandom % 20) == 0;
            rob_squashing[t] = ($urandom % 25) == 0;
            dec_squash[t]    = ($urandom % 12) == 0;
            cmt_target[t*PW +: PW] = PW'($urandom) & ~PW'(3);
            dec_target[t*PW +: PW] = PW'($urandom) & ~PW'(3);
        end
        ctx_switch   = ($urandom % 40) == 0;
        req_valid    = ($urandom % 3) == 0;
        req_accepted = ($urandom % 4) != 0;
        req_tid      = TIDW'($urandom % NT);
        req_tag      = TW'($urandom);
        retry_grant  = ($urandom % 6) == 0;
        rsp_valid    = ($urandom % 3) == 0;
        rsp_tid      = TIDW'($urandom % NT);
        rsp_tag      = ($urandom % 2) ? m_tag[rsp_tid] : TW'($urandom);
        if (($urandom % 50) == 0) thr_active = NT'($urandom);
    endtask

    bit done = 0;
    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        quiet();
        thr_active = '1; cmt_target = '0; dec_target = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 state0", int'(thr_state[2:0]), 0);
        chk("R1 pc1", int'(thr_pc[PW +: PW]), int'(RPC));
        chk("R1 npc0", int'(thr_npc[0 +: PW]), int'(RPC) + IB);
        chk("R1 blocked", int'(cache_blocked), 0);
        chk("R1 active", int'(stage_active), 1);

        // R2 sticky stall from stage 2 on thread 0
        stall_set[2*NT+0] = 1'b1; step(); quiet();
        chk("R2 blocked", int'(thr_state[2:0]), 2);
        step(); chk("R2 stays blocked", int'(thr_state[2:0]), 2);
        stall_clr[2*NT+0] = 1'b1; step(); quiet();
        chk("R2 unblocked", int'(thr_state[2:0]), 0);

        // R8 accepted issue, R9 stale tag, R10 matching tag
        req_valid = 1; req_tid = 1; req_tag = 2; req_accepted = 1; step(); quiet();
        chk("R8 wait resp", int'(thr_state[5:3]), 3);
        rsp_valid = 1; rsp_tid = 1; rsp_tag = 1; #1;
        chk("R9 stale tag dropped", int'(resp_dropped), 1);
        step(); chk("R9 state kept", int'(thr_state[5:3]), 3);
        rsp_tag = 2; step(); quiet();
        chk("R10 access done", int'(thr_state[5:3]), 5);
        step(); chk("R10 back to run", int'(thr_state[5:3]), 0);

        // R8 refused issue, blocked cache ignores other issues, R11 grant
        req_valid = 1; req_tid = 0; req_tag = 3; req_accepted = 0; step(); quiet();
        chk("R8 wait retry", int'(thr_state[2:0]), 4);
        chk("R11 blocked set", int'(cache_blocked), 1);
        req_valid = 1; req_tid = 1; req_accepted = 1; step(); quiet();
        chk("R8 issue ignored while blocked", int'(thr_state[5:3]), 0);
        retry_grant = 1; step(); quiet();
        chk("R11 grant to wait resp", int'(thr_state[2:0]), 3);
        chk("R11 blocked cleared", int'(cache_blocked), 0);

        // R3 retire redirect, R4 hold, R5 decode ignored, R7 recovery
        cmt_squash[0] = 1; cmt_target[0 +: PW] = 16'h0100; step(); quiet();
        chk("R3 squash", int'(thr_state[2:0]), 1);
        chk("R3 pc", int'(thr_pc[0 +: PW]), 16'h0100);
        chk("R3 npc", int'(thr_npc[0 +: PW]), 16'h0104);
        rob_squashing[0] = 1; step(); quiet();
        chk("R4 held", int'(thr_state[2:0]), 1);
        dec_squash[0] = 1; dec_target[0 +: PW] = 16'h0200; rob_squashing[0] = 1; step(); quiet();
        chk("R5 decode ignored", int'(thr_pc[0 +: PW]), 16'h0100);
        step(); chk("R7 to run", int'(thr_state[2:0]), 0);
        // R3 abandoned request: the old tag no longer matches a live wait
        rsp_valid = 1; rsp_tid = 0; rsp_tag = 3; #1;
        chk("R3 R9 cancelled response dropped", int'(resp_dropped), 1);
        step(); quiet();

        // R6 context switch
        ctx_switch = 1; step(); quiet();
        chk("R6 t0 blocked", int'(thr_state[2:0]), 2);
        chk("R6 t1 blocked", int'(thr_state[5:3]), 2);
        chk("R12 inactive when all blocked", int'(stage_active), 0);
        step();

        // R12 thread mask
        thr_active = '0; #1;
        chk("R12 masked", int'(stage_active), 0);
        thr_active = '1;

        for (int i = 0; i < 4000; i++) begin
            rand_inputs();
            step();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule